// File: doc/BRIEF.md
# T1 Frame Alignment Searcher

This block finds the framing bit in a serial DS1 stream of 193-bit frames. Each bit slot in the frame is a candidate. For every candidate the block keeps a small record in a 193-entry candidate memory. The record holds a 3-bit history per frame-phase substream and a survival flag per framing-phase hypothesis. As each bit arrives, the block reads the record for that slot, predicts the bit from the history, and drops every hypothesis that the bit contradicts. It then writes the record back.

Two framing formats are supported. In D4 (superframe) mode the terminal framing bits sit on alternate frames and are checked. The signalling framing bits on the other frames are checked too when cross-checking is enabled. In ESF (extended superframe) mode the framing pattern bits in every fourth frame are checked.

A decision is made at each search-frame end once ten framing bits have been seen. If exactly one slot survives, the block locks to it. If none survives, the search starts over. If several survive at the 24-bit timeout, the block locks to the next surviving slot that arrives. A one-cycle reframe request drops lock. The new search then starts at the slot just after the old framing bit, so a mimic that won before is the last slot reconsidered.

Top module: `t1_frame_search`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `in_frame` is 0 and `bit_pos` is 0; a reset taken while locked drops lock.
- R2: A candidate slot is eliminated when a checked bit does not equal the value predicted from its 3-bit history (a history window that never occurs in the pattern also eliminates it); an all-zero slot never survives a check.
- R3: If exactly one slot survives at the end of search frame 10·S−1 (S = 2 in D4, 4 in ESF; frames counted from 0 at search start), `in_frame` rises on the edge that accepts bit 192 of that frame, and `bit_pos` then reads 192 − L, where L is the surviving slot's index from search start.
- R4: If no slot survives at a decision point, the search restarts: the next bit becomes slot 0 of search frame 0.
- R5: If two or more slots still survive at the end of search frame 24·S−1, the block locks on the first surviving slot accepted after that point, with `bit_pos` = 0 on that bit.
- R6: In D4 mode (`esf_mode` = 0), the terminal framing substream alternates 1,0,1,0 on every other frame, and either frame parity is accepted.
- R7: With `fs_check_en` = 1 in D4 mode, the other frame parity must follow 0,0,1,1,1,0 repeating, or the slot is eliminated. With `fs_check_en` = 0, that parity is not checked.
- R8: In ESF mode (`esf_mode` = 1), one of the four frame phases must follow 0,0,1,0,1,1 repeating; any phase is accepted and the other three phases are not checked.
- R9: A one-cycle `reframe` while locked drops `in_frame` on the next edge. The new search treats the bit at aligned position 1 as slot 0.
- R10: While locked, `bit_pos` advances by one per accepted bit and wraps from 192 to 0; it holds when `bit_en` is low. While not locked, it reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial line bit |
| bit_en | input | 1 | Qualifies `bit_in` for one cycle |
| esf_mode | input | 1 | 0 = D4 format, 1 = ESF format; sampled when a search starts |
| fs_check_en | input | 1 | D4 signalling framing cross-check enable; sampled when a search starts |
| reframe | input | 1 | One-cycle request to drop lock and search again |
| in_frame | output | 1 | High while aligned |
| bit_pos | output | 8 | Aligned bit position, 0 = framing bit |

## Verification
All results are registered on the same edge that accepts the deciding bit. The lock of R3 and R5 and each count step of R10 therefore show up on the edge that takes the bit, and the lock drop of R9 shows up on the edge after the request.

The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It compares every cycle against a model that knows the exact accepted-bit index at which lock is due, and that index is computed from the search-frame arithmetic in the requirements. Idle cycles inserted between bits are compared against the last expected value, which checks the hold behaviour.

// File: rtl/t1fs_pkg.sv
package t1fs_pkg;

  localparam int NSUB = 4;

  typedef enum logic [1:0] {ST_SEARCH, ST_PICK, ST_LOCK, ST_WAIT} st_t;

  typedef struct packed {
    logic [NSUB-1:0]      alive;
    logic [NSUB-1:0][2:0] hist;
  } cand_t;

  // Patterns in time order, element 0 first.
  localparam logic [5:0] PAT_FT  = 6'b010101;  // 1,0,1,0,1,0
  localparam logic [5:0] PAT_FS  = 6'b011100;  // 0,0,1,1,1,0
  localparam logic [5:0] PAT_FPS = 6'b110100;  // 0,0,1,0,1,1

  // Returns {window_found, predicted_next}; h[2] is the oldest bit.
  function automatic logic [1:0] predict(input logic [5:0] pat, input logic [2:0] h);
    logic [1:0] r;
    r = 2'b00;
    for (int i = 0; i < 6; i++) begin
      if ({pat[i], pat[(i+1)%6], pat[(i+2)%6]} == h)
        r = {1'b1, pat[(i+3)%6]};
    end
    return r;
  endfunction

endpackage

// File: rtl/t1fs_cand_mem.sv
module t1fs_cand_mem #(
  parameter int DEPTH = 193,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];

  assign rdata = ram[addr];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
  end
endmodule

// File: rtl/t1fs_cand_upd.sv
module t1fs_cand_upd
  import t1fs_pkg::*;
(
  input  cand_t      cur,
  input  logic       bit_in,
  input  logic [1:0] sub,
  input  logic       hist_ok,
  input  logic       init,
  input  logic       esf,
  input  logic       xchk,
  output cand_t      nxt,
  output logic       any_alive
);
  logic [2:0]      h_sel;
  logic [NSUB-1:0] alive_n;

  assign h_sel = cur.hist[sub];

  for (genvar g = 0; g < NSUB; g++) begin : g_hyp
    logic       is_frm;
    logic       chk;
    logic [5:0] pat;
    logic [1:0] pr;
    logic       bad;
    always_comb begin
      is_frm = esf ? (sub == 2'(g)) : (sub[0] == 1'(g % 2));
      pat    = esf ? PAT_FPS : (is_frm ? PAT_FT : PAT_FS);
      chk    = hist_ok && (is_frm || (!esf && xchk));
      pr     = predict(pat, h_sel);
      bad    = chk && (!pr[1] || (pr[0] != bit_in));
    end
    assign alive_n[g] = init ? (esf || (g < 2)) : (cur.alive[g] & ~bad);
  end

  always_comb begin
    nxt.hist      = cur.hist;
    nxt.hist[sub] = {h_sel[1:0], bit_in};
    nxt.alive     = alive_n;
    any_alive     = |alive_n;
  end
endmodule

// File: rtl/t1_frame_search.sv
module t1_frame_search
  import t1fs_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int HIST_BITS  = 10,
  parameter int TMO_BITS   = 24,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_en,
  input  logic             esf_mode,
  input  logic             fs_check_en,
  input  logic             reframe,
  output logic             in_frame,
  output logic [POS_W-1:0] bit_pos
);
  localparam int FW = $clog2(TMO_BITS * NSUB + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  st_t              st;
  logic [POS_W-1:0] sidx, apos, surv_idx, apos_nx, idx_new;
  logic [FW-1:0]    fcnt, hist_end, tmo_end;
  logic [1:0]       surv_cnt, cnt_in, cnt_new, sub;
  logic             esf_q, xchk_q;
  logic             hist_ok, init, any_alive, proc, frame_end;
  cand_t            rd, wr;

  t1fs_cand_mem #(.DEPTH(FRAME_BITS), .W($bits(cand_t))) u_mem (
    .clk(clk), .we(proc), .addr(sidx), .wdata(wr), .rdata(rd)
  );

  t1fs_cand_upd u_upd (
    .cur(rd), .bit_in(bit_in), .sub(sub), .hist_ok(hist_ok), .init(init),
    .esf(esf_q), .xchk(xchk_q), .nxt(wr), .any_alive(any_alive)
  );

  always_comb begin
    sub       = esf_q ? fcnt[1:0] : {1'b0, fcnt[0]};
    hist_ok   = esf_q ? ((fcnt >> 2) >= FW'(3)) : ((fcnt >> 1) >= FW'(3));
    init      = (fcnt == '0);
    hist_end  = esf_q ? FW'(HIST_BITS * 4 - 1) : FW'(HIST_BITS * 2 - 1);
    tmo_end   = esf_q ? FW'(TMO_BITS * 4 - 1)  : FW'(TMO_BITS * 2 - 1);
    apos_nx   = (apos == LAST) ? '0 : apos + 1'b1;
    frame_end = (sidx == LAST);
    proc      = bit_en && !reframe &&
                ((st == ST_SEARCH) || ((st == ST_WAIT) && (apos_nx == POS_W'(1))));
    cnt_in    = (sidx == '0) ? 2'd0 : surv_cnt;
    cnt_new   = any_alive ? ((cnt_in == 2'd0) ? 2'd1 : 2'd2) : cnt_in;
    idx_new   = (any_alive && (cnt_in == 2'd0)) ? sidx : surv_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_SEARCH;
      sidx     <= '0;
      fcnt     <= '0;
      apos     <= '0;
      bit_pos  <= '0;
      in_frame <= 1'b0;
      surv_cnt <= '0;
      surv_idx <= '0;
      esf_q    <= esf_mode;
      xchk_q   <= fs_check_en;
    end else begin
      if (bit_en) apos <= apos_nx;
      case (st)
        ST_SEARCH, ST_WAIT: begin
          if (reframe) begin
            sidx   <= '0;
            fcnt   <= '0;
            esf_q  <= esf_mode;
            xchk_q <= fs_check_en;
          end else if (proc) begin
            st       <= ST_SEARCH;
            surv_cnt <= cnt_new;
            surv_idx <= idx_new;
            if (frame_end) begin
              sidx <= '0;
              fcnt <= fcnt + 1'b1;
              if (fcnt >= hist_end) begin
                if (cnt_new == 2'd1) begin
                  st       <= ST_LOCK;
                  in_frame <= 1'b1;
                  apos     <= LAST - idx_new;
                  bit_pos  <= LAST - idx_new;
                end else if (cnt_new == 2'd0) begin
                  fcnt   <= '0;
                  esf_q  <= esf_mode;
                  xchk_q <= fs_check_en;
                end else if (fcnt == tmo_end) begin
                  st <= ST_PICK;
                end
              end
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
        end
        ST_PICK: begin
          if (reframe) begin
            st     <= ST_SEARCH;
            sidx   <= '0;
            fcnt   <= '0;
            esf_q  <= esf_mode;
            xchk_q <= fs_check_en;
          end else if (bit_en) begin
            if (|rd.alive) begin
              st       <= ST_LOCK;
              in_frame <= 1'b1;
              apos     <= '0;
              bit_pos  <= '0;
            end else begin
              sidx <= frame_end ? '0 : sidx + 1'b1;
            end
          end
        end
        default: begin
          if (reframe) begin
            st       <= ST_WAIT;
            in_frame <= 1'b0;
            bit_pos  <= '0;
            sidx     <= '0;
            fcnt     <= '0;
            esf_q    <= esf_mode;
            xchk_q   <= fs_check_en;
          end else if (bit_en) begin
            bit_pos <= apos_nx;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/t1fs_checker.sv
module t1fs_checker #(
  parameter int FRAME_BITS = 193,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             reframe,
  input logic             in_frame,
  input logic [POS_W-1:0] bit_pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!in_frame && bit_pos == '0)); // R1

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_pos <= LAST); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !in_frame |-> (bit_pos == '0)); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_frame && bit_en && !reframe) |=>
      (in_frame && bit_pos == (($past(bit_pos) == LAST) ? '0 : $past(bit_pos) + 1'b1))); // R10

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !bit_en && !reframe) |=> (in_frame && $stable(bit_pos))); // R10

  AST_REFRAME_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_frame && reframe) |=> !in_frame); // R9

  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && !bit_en) |=> !in_frame); // R3
endmodule

bind t1_frame_search t1fs_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .reframe(reframe),
  .in_frame(in_frame), .bit_pos(bit_pos)
);

// File: tb/t1_frame_search_test.sv
module t1_frame_search_test;
  localparam int FB = 193;
  // {esf, xchk, gap, lead, fpos[7:0], mimic[7:0]}; mimic 255 = none
  localparam logic [19:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd37,  8'd255},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd0,   8'd255},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd192, 8'd255},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd100, 8'd20},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd100, 8'd20},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'd5,   8'd255},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd60,  8'd255}
  };
  localparam bit FS_SEQ  [6] = '{0, 0, 1, 1, 1, 0};
  localparam bit FPS_SEQ [6] = '{0, 0, 1, 0, 1, 1};

  logic clk = 0, rst = 1, bit_in = 0, bit_en = 0;
  logic esf_mode = 0, fs_check_en = 0, reframe = 0;
  logic in_frame;
  logic [7:0] bit_pos;

  int n_vec = 0, n_bad = 0;
  int c_esf, c_xchk, c_gap, c_lead, c_fpos, c_mim;
  int idx, lock_at, lock_l;
  string tag;

  always #5 clk = ~clk;

  t1_frame_search uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en), .esf_mode(esf_mode),
    .fs_check_en(fs_check_en), .reframe(reframe), .in_frame(in_frame), .bit_pos(bit_pos)
  );

  function automatic logic stream_bit(int i);
    int q, m;
    q = i % FB;
    m = i / FB - c_lead * 20;
    if (m < 0) return 1'b0;
    if (q == c_fpos) begin
      if (c_esf != 0) begin
        if (m % 4 == 0) return FPS_SEQ[(m / 4) % 6];
        return (m % 4 == 2);
      end
      if (m % 2 == 0) return ((m / 2) % 2 == 0);
      return FS_SEQ[((m - 1) / 2) % 6];
    end
    if (q == c_mim) return (m % 2 == 0) ? ((m / 2) % 2 == 0) : 1'b0;
    return 1'b0;
  endfunction

  task automatic check(input logic ef, input int ep, input string t);
    n_vec++;
    if (in_frame !== ef || int'(bit_pos) != ep) begin
      n_bad++;
      $display("FAIL %s: in_frame=%0d bit_pos=%0d expected in_frame=%0d bit_pos=%0d",
               t, in_frame, bit_pos, ef, ep);
    end
  endtask

  task automatic expect_now();
    int li;
    li = idx - 1;
    if (idx == 0 || li < lock_at) check(1'b0, 0, tag);
    else check(1'b1, ((li % FB) - lock_l + FB) % FB, tag);
  endtask

  task automatic send_bit();
    if (c_gap != 0 && idx % 3 == 2) begin
      @(negedge clk); bit_en = 0;
      @(posedge clk); #1; expect_now();  // hold on idle cycle, R10
    end
    @(negedge clk); bit_in = stream_bit(idx); bit_en = 1;
    @(posedge clk); #1;
    idx++;
    expect_now();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bit_en = 0; reframe = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    #1; check(1'b0, 0, "R1 reset state");
    idx = 0;
  endtask

  task automatic setup(input int i);
    logic [19:0] v;
    int step;
    v = VEC[i];
    c_esf = v[19]; c_xchk = v[18]; c_gap = v[17]; c_lead = v[16];
    c_fpos = v[15:8]; c_mim = v[7:0];
    esf_mode = v[19]; fs_check_en = v[18];
    step = (c_esf != 0) ? 4 : 2;
    if (c_mim != 255 && c_xchk == 0) begin
      lock_l  = (c_fpos < c_mim) ? c_fpos : c_mim;
      lock_at = c_lead * 20 * FB + 24 * step * FB + lock_l;
    end else begin
      lock_l  = c_fpos;
      lock_at = c_lead * 20 * FB + (10 * step - 1) * FB + 192;
    end
    case (i)
      0: tag = "R3 R6 R2 single survivor D4";
      1: tag = "R7 R3 cross-check slot 0";
      2: tag = "R8 R3 ESF slot 192";
      3: tag = "R5 R2 mimic timeout pick";
      4: tag = "R7 R2 mimic killed by Fs check";
      5: tag = "R4 restart after empty search";
      default: tag = "R8 R10 ESF with idle gaps";
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int ns;
    lock_at = 0; lock_l = 0; idx = 0; tag = "R1";
    for (int i = 0; i < 7; i++) begin
      setup(i);
      do_reset();
      while (idx < lock_at + 2 * FB) send_bit();
    end

    // Directed: reframe after locking on a mimic moves lock to the true slot.
    setup(3);
    tag = "R9 R5 locked on mimic before reframe";
    do_reset();
    while (idx < lock_at + 300) send_bit();
    @(negedge clk); bit_en = 0; reframe = 1;
    @(posedge clk); #1;
    check(1'b0, 0, "R9 lock drops after reframe");
    @(negedge clk); reframe = 0;
    ns      = idx + ((21 - (idx % FB) + FB) % FB);
    lock_at = ns + 48 * FB + 79;
    lock_l  = 100;
    tag = "R9 search resumes past old lock";
    while (idx < lock_at + 2 * FB) send_bit();

    // Directed: reset while locked.
    do_reset();
    @(negedge clk); bit_en = 0;
    @(posedge clk); #1;
    check(1'b0, 0, "R1 idle after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule